// File: doc/BRIEF.md
# Selectable converter result averager

This block drives an 8-bit analog-to-digital converter and presents its results on an 8-bit output port. At the start of every conversion it reads a 3-bit channel code from external pins and sends that code to the converter as the channel select. The code chooses one of four external inputs or an internal calibration level. The channel can therefore be moved at any time without a reset. Conversions follow one another without pause once reset is released. The converter is modelled as a handshake: a one-cycle start pulse goes out, and a done pulse comes back with the 8-bit result.

A mode pin sets what the port shows. With the pin low, every result goes straight to the port. With it high, the block adds four consecutive results and shows their sum divided by four, rounded down. A data-valid strobe goes low before the port value changes. It rises in the same cycle as the new value and stays high for as long as that value is held. If the channel code or the mode pin differs from the previous conversion, any partial sum is discarded and the group of four starts again.

Top module: `conv_result_averager`

## Requirements
- R1: While rst_n is low, conv_start, out_valid, conv_chan and out_data are all 0.
- R2: conv_start is a pulse exactly one cycle wide. The next pulse is raised on the clock edge that follows the edge at which a result was accepted, so conversions follow one another continuously.
- R3: conv_chan takes the value of chan_pins sampled at the edge that raises conv_start, and holds it until the next such edge.
- R4: When avg_mode was 0 at the start of a conversion, that conversion's result is published to out_data unchanged.
- R5: When avg_mode was 1, the first three results of a group are only added to a sum. The fourth result publishes (r0+r1+r2+r3)/4, truncated, with the sum held in 10 bits so that 4 x 255 gives 255.
- R6: When a result is published, out_valid falls on the accepting edge, and out_data takes the new value with out_valid rising on the next edge. out_data never changes on an edge at which out_valid was high just before.
- R7: At a conversion start where chan_pins or avg_mode differs from the values latched for the previous conversion, the partial sum and its count are cleared.
- R8: conv_done is ignored unless a conversion is outstanding and conv_start is low. A done pulse that arrives during the start cycle neither publishes a result nor adds to the sum.
- R9: A published value and out_valid=1 are held until the next publication, whatever happens to chan_pins and avg_mode in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chan_pins | input | 3 | Channel code, read at each conversion start |
| avg_mode | input | 1 | 0 = raw results, 1 = average of four |
| conv_start | output | 1 | One-cycle start request to the converter |
| conv_chan | output | 3 | Channel select held for the current conversion |
| conv_done | input | 1 | Converter result-ready pulse |
| conv_data | input | 8 | Converter result, valid with conv_done |
| out_data | output | 8 | Published result |
| out_valid | output | 1 | High while out_data is stable and valid |

## Verification
A wrong sum or a wrong group count shows up at the fourth result of a group: the published average is then off, or the strobe dips one conversion too early or too late. A failure to clear after a channel or mode change shows the same way, in the first group after the change. A stale channel latch appears at conv_chan as soon as conv_start rises. Wrong gating of done appears within two cycles as an early strobe dip or a sum that includes a spurious value. The reference model is compared on every clock, so each of these faults is reported within a few cycles of its cause.

// File: rtl/conv_result_averager.sv
module conv_result_averager #(
  parameter int DW = 8,
  parameter int CW = 3,
  parameter int AVG_LOG = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] chan_pins,
  input  logic          avg_mode,
  output logic          conv_start,
  output logic [CW-1:0] conv_chan,
  input  logic          conv_done,
  input  logic [DW-1:0] conv_data,
  output logic [DW-1:0] out_data,
  output logic          out_valid
);
  localparam int SW = DW + AVG_LOG;
  localparam logic [AVG_LOG-1:0] LAST = '1;

  logic               waiting;
  logic               mode_q;
  logic [SW-1:0]      acc;
  logic [AVG_LOG-1:0] cnt;
  logic               pend;
  logic [DW-1:0]      hold;
  logic [SW-1:0]      sum;
  logic               take;

  assign sum  = acc + SW'(conv_data);
  assign take = waiting && conv_done && !conv_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waiting    <= 1'b0;
      conv_start <= 1'b0;
      conv_chan  <= '0;
      mode_q     <= 1'b0;
      acc        <= '0;
      cnt        <= '0;
      pend       <= 1'b0;
      hold       <= '0;
      out_data   <= '0;
      out_valid  <= 1'b0;
    end else begin
      conv_start <= 1'b0;
      pend       <= 1'b0;
      if (pend) begin
        out_data  <= hold;
        out_valid <= 1'b1;
      end
      if (!waiting) begin
        conv_chan  <= chan_pins;
        mode_q     <= avg_mode;
        conv_start <= 1'b1;
        waiting    <= 1'b1;
        if (chan_pins != conv_chan || avg_mode != mode_q) begin
          acc <= '0;
          cnt <= '0;
        end
      end else if (take) begin
        waiting <= 1'b0;
        if (!mode_q) begin
          hold      <= conv_data;
          pend      <= 1'b1;
          out_valid <= 1'b0;
        end else if (cnt == LAST) begin
          hold      <= sum[SW-1:AVG_LOG];
          pend      <= 1'b1;
          out_valid <= 1'b0;
          acc       <= '0;
          cnt       <= '0;
        end else begin
          acc <= sum;
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

module conv_result_averager_chk #(
  parameter int DW = 8,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          conv_start,
  input logic [CW-1:0] conv_chan,
  input logic [DW-1:0] conv_data,
  input logic [DW-1:0] out_data,
  input logic          out_valid,
  input logic          mode_q
);
  assert_start_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  assert_chan_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(conv_start) |-> $stable(conv_chan));

  assert_raw_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(out_valid) && !$past(mode_q)) |-> out_data == $past(conv_data, 2));

  assert_no_change_while_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_data != $past(out_data)) |-> !$past(out_valid));

  assert_dip_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |=> out_valid);
endmodule

bind conv_result_averager conv_result_averager_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .conv_chan(conv_chan),
  .conv_data(conv_data), .out_data(out_data), .out_valid(out_valid), .mode_q(mode_q)
);

// File: tb/conv_result_averager_tb.sv
module conv_result_averager_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] chan_pins = 3'd0;
  logic       avg_mode = 1'b0;
  logic       conv_start;
  logic [2:0] conv_chan;
  logic       conv_done = 1'b0;
  logic [7:0] conv_data = 8'd0;
  logic [7:0] out_data;
  logic       out_valid;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done_run = 1'b0;

  always #10 clk = ~clk;

  conv_result_averager u_dut (
    .clk(clk), .rst_n(rst_n), .chan_pins(chan_pins), .avg_mode(avg_mode),
    .conv_start(conv_start), .conv_chan(conv_chan), .conv_done(conv_done),
    .conv_data(conv_data), .out_data(out_data), .out_valid(out_valid)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // converter stub controls
  int  pat = 0;
  bit  glitch = 1'b0;
  int  lat = 0;
  int  nconv = 0;
  int  seed = 7;
  logic [7:0] pending_val = 8'd0;

  // behavioural reference
  bit   m_wait = 0, m_start = 0, m_valid = 0, m_pend = 0, m_mode = 0;
  int   m_chan = 0, m_out = 0, m_hold = 0;
  int   q[$];

  function automatic int qsum();
    int s = 0;
    foreach (q[i]) s += q[i];
    return s;
  endfunction

  always @(posedge clk) begin
    #2;
    cycles++;
    if (!rst_n) begin
      m_wait = 0; m_start = 0; m_valid = 0; m_pend = 0; m_mode = 0;
      m_chan = 0; m_out = 0; m_hold = 0; q.delete();
    end else begin
      bit nv, np, ns;
      int nd;
      nv = m_valid; nd = m_out; np = 0; ns = 0;
      if (m_pend) begin nd = m_hold; nv = 1; end
      if (!m_wait) begin
        if (int'(chan_pins) != m_chan || avg_mode != m_mode) q.delete();   // R7
        m_chan = chan_pins; m_mode = avg_mode; ns = 1; m_wait = 1;
      end else if (conv_done && !m_start) begin                            // R8
        m_wait = 0;
        if (!m_mode) begin
          m_hold = conv_data; np = 1; nv = 0;                              // R4
        end else begin
          q.push_back(int'(conv_data));
          if (q.size() == 4) begin
            m_hold = qsum() / 4; np = 1; nv = 0; q.delete();               // R5
          end
        end
      end
      m_start = ns; m_out = nd; m_valid = nv; m_pend = np;
    end
    check("R1 R2 conv_start", conv_start, m_start);
    check("R3 conv_chan", conv_chan, m_chan);
    check("R4 R5 R7 R8 out_data", out_data, m_out);
    check("R6 R9 out_valid", out_valid, m_valid);

    // converter stub, drives away from the edge
    conv_done = 1'b0;
    if (lat > 0) begin
      lat--;
      if (lat == 0) begin conv_done = 1'b1; conv_data = pending_val; end
    end
    if (rst_n && conv_start) begin
      nconv++;
      lat = 1 + (nconv % 3);
      case (pat)
        1: pending_val = 8'd255;
        2: pending_val = ((nconv % 4) == 0) ? 8'd2 : 8'd1;
        default: begin seed = (seed * 73 + 17 + conv_chan) % 256; pending_val = 8'(seed); end
      endcase
      if (glitch) begin conv_done = 1'b1; conv_data = 8'hA5; end           // R8 stray done
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    run(3);
    check("R1 reset out_valid", out_valid, 0);
    check("R1 reset out_data", out_data, 0);
    check("R1 reset conv_start", conv_start, 0);
    rst_n = 1'b1;
    chan_pins = 3'd5; avg_mode = 1'b0;
    run(60);
    chan_pins = 3'd2;
    run(40);
    avg_mode = 1'b1;
    run(120);
    pat = 1; run(80);                                   // R5 full scale
    check("R5 full-scale average", out_data, 255);
    pat = 2; run(100);                                  // R5 truncation of 5/4
    check("R5 truncated average", out_data, 1);
    pat = 0; glitch = 1'b1; run(80);
    for (int i = 0; i < 10; i++) begin chan_pins = 3'(i); run(7); end       // R7
    for (int i = 0; i < 8; i++) begin avg_mode = ~avg_mode; run(9); end     // R7 R9
    avg_mode = 1'b1; glitch = 1'b0;
    for (int i = 0; i < 4; i++) begin chan_pins = 3'(7 - i); run(23); end
    run(100);
    rst_n = 1'b0; run(2);
    check("R1 reset again out_valid", out_valid, 0);
    rst_n = 1'b1; avg_mode = 1'b0; run(30);
    done_run = 1'b1;
  end

  initial begin
    wait (done_run || cycles > 150000);
    if (!done_run) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule